// File: doc/BRIEF.md
# Multi-Core Segment Register Bank

This block holds the relocation state for a group of cores. Every core owns eight 32-bit segment registers. Four are bases, for code, data, stack and extra. The other four are the matching limits. The bank drives all of a core's bases and limits continuously to that core's address translator. Each core also has a local port. Through it the core reads a register (get) or overwrites one (set). The lower four indices select the bases. Adding four to an index selects the matching limit.

A single shared port carries a cross-core initialise command. Supervisory code uses it to prepare a core before that core starts. The command packs a 9-bit destination field with a lock bit, a target core number and a register number, and carries a 32-bit value alongside. The command is dropped if the target is currently running. When it is accepted, it writes the value and also latches the lock bit. The lock bit decides whether the target core may later rewrite its own registers. Only the indices that the parameter `IMPL_MASK` marks as implemented hold state. By default these are the code, data and stack bases and the data and stack limits.

Top module: `seg_bank`

## Requirements
- R1: After reset every segment register of every core reads zero on all outputs, every lock bit is clear and no get result is flagged valid.
- R2: A local set on core c with index n writes the data into register n of core c. Index encoding: 0 code base, 1 data base, 2 stack base, 3 extra base, 4 code limit, 5 data limit, 6 stack limit, 7 extra limit. The new value is visible on the output one cycle later. Base slot k of core c is `seg_base_o[(c*4+k)*32 +: 32]`, and limit slot k is the same slice of `seg_lim_o`.
- R3: A local get returns the register's value from before any write in the same cycle. The value appears on that core's read data one cycle after the request, with the valid strobe high for exactly that cycle. The strobe is low in cycles that follow no request.
- R4: The initialise destination field is decoded as follows: bit 8 is the lock bit, bits 5:3 are the target core, bits 2:0 are the register index, and bits 7:6 are ignored. When the target is not running, the command writes the 32-bit source value into that register and latches the lock bit.
- R5: An initialise command whose target core has its running input high changes neither the target's registers nor its lock bit.
- R6: While a core's lock bit is 1, its local sets are ignored. While the bit is 0, they take effect. The lock state used is the one in force in the cycle of the set.
- R7: Indices 3, 4 and 7 are reserved. Writes to them by either path are ignored, and they read as zero on the outputs and through get.
- R8: If a local set and an accepted initialise hit the same register in the same cycle, the initialise value is stored. If they hit different registers, both writes take effect.
- R9: A local operation on one core never changes any other core's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_run_i | input | NUM_CORES | Per-core running flag |
| loc_set_i | input | NUM_CORES | Per-core local set request |
| loc_get_i | input | NUM_CORES | Per-core local get request |
| loc_idx_i | input | NUM_CORES*3 | Per-core register index |
| loc_wdata_i | input | NUM_CORES*DATA_W | Per-core set data |
| loc_rdata_o | output | NUM_CORES*DATA_W | Per-core get result |
| loc_rvalid_o | output | NUM_CORES | Per-core get result valid |
| init_valid_i | input | 1 | Cross-core initialise command valid |
| init_dst_i | input | 9 | Packed lock / core / index field |
| init_src_i | input | DATA_W | Initialise value |
| seg_base_o | output | NUM_CORES*4*DATA_W | All cores' base registers |
| seg_lim_o | output | NUM_CORES*4*DATA_W | All cores' limit registers |

## Verification
All register state is driven straight onto `seg_base_o` and `seg_lim_o`. A wrong write, a missed write or a write to the wrong core therefore shows on the outputs in the cycle after the offending edge, and the bench compares every core's full output on every cycle. The lock bit has no output of its own. A wrong lock value shows up at the next local set on that core, which is why the stimulus keeps issuing sets after initialise commands. A read-path fault shows on read data only in the cycle after a get, so gets are issued on most cycles.

// File: rtl/seg_bank_pkg.sv
package seg_bank_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_SEGS = 8;
  localparam int unsigned HALF     = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_CODE_BASE  = 3'd0,
    SEL_DATA_BASE  = 3'd1,
    SEL_STACK_BASE = 3'd2,
    SEL_EXTRA_BASE = 3'd3,
    SEL_CODE_LIM   = 3'd4,
    SEL_DATA_LIM   = 3'd5,
    SEL_STACK_LIM  = 3'd6,
    SEL_EXTRA_LIM  = 3'd7
  } seg_sel_e;

  // bit 8 lock, 7:6 ignored, 5:3 core, 2:0 index
  typedef struct packed {
    logic             lock;
    logic [1:0]       unused;
    logic [2:0]       core;
    logic [SEL_W-1:0] sel;
  } init_dst_t;

  localparam logic [NUM_SEGS-1:0] IMPL_DEFAULT = 8'b0110_0111;
endpackage

// File: rtl/seg_init_decode.sv
module seg_init_decode
  import seg_bank_pkg::*;
#(
  parameter int unsigned NUM_CORES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_valid_i,
  input  logic [8:0]           init_dst_i,
  input  logic [NUM_CORES-1:0] core_run_i,
  output logic [NUM_CORES-1:0] init_we_o,
  output logic [SEL_W-1:0]     init_sel_o,
  output logic                 init_lock_o
);
  init_dst_t dst;
  assign dst         = init_dst_t'(init_dst_i);
  assign init_sel_o  = dst.sel;
  assign init_lock_o = dst.lock;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_tgt
    assign init_we_o[c] = init_valid_i && (dst.core == 3'(c)) && !core_run_i[c];
  end

  a_r4_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(init_we_o));
endmodule

// File: rtl/seg_core_regs.sv
module seg_core_regs
  import seg_bank_pkg::*;
#(
  parameter int unsigned          DATA_W    = 32,
  parameter logic [NUM_SEGS-1:0]  IMPL_MASK = IMPL_DEFAULT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_we_i,
  input  logic [SEL_W-1:0]     init_sel_i,
  input  logic                 init_lock_i,
  input  logic [DATA_W-1:0]    init_data_i,
  input  logic                 loc_set_i,
  input  logic                 loc_get_i,
  input  logic [SEL_W-1:0]     loc_idx_i,
  input  logic [DATA_W-1:0]    loc_wdata_i,
  output logic [DATA_W-1:0]    loc_rdata_o,
  output logic                 loc_rvalid_o,
  output logic [HALF*DATA_W-1:0] base_o,
  output logic [HALF*DATA_W-1:0] lim_o
);
  localparam int unsigned FLAT_W = NUM_SEGS * DATA_W;

  logic [DATA_W-1:0] regs_q [NUM_SEGS];
  logic [FLAT_W-1:0] regs_flat;
  logic              lock_q;
  logic              loc_ok;

  assign loc_ok = loc_set_i && !lock_q;

  for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
    if (IMPL_MASK[i]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          regs_q[i] <= '0;
        end else if (init_we_i && init_sel_i == SEL_W'(i)) begin
          regs_q[i] <= init_data_i;   // initialise wins
        end else if (loc_ok && loc_idx_i == SEL_W'(i)) begin
          regs_q[i] <= loc_wdata_i;
        end
      end

      a_r8_init_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (init_we_i && init_sel_i == SEL_W'(i)) |=> (regs_q[i] == $past(init_data_i)));
    end else begin : g_rsvd
      assign regs_q[i] = '0;
    end
    assign regs_flat[i*DATA_W +: DATA_W] = regs_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= 1'b0;
    else if (init_we_i) lock_q <= init_lock_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_rvalid_o <= 1'b0;
      loc_rdata_o  <= '0;
    end else begin
      loc_rvalid_o <= loc_get_i;
      if (loc_get_i) loc_rdata_o <= regs_q[loc_idx_i];
    end
  end

  assign base_o = regs_flat[0 +: HALF*DATA_W];
  assign lim_o  = regs_flat[HALF*DATA_W +: HALF*DATA_W];

  a_r6_locked_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !init_we_i) |=> $stable(regs_flat));

  a_r3_rvalid_follows_get: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_get_i |=> loc_rvalid_o);

  a_r3_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_get_i |=> !loc_rvalid_o);
endmodule

// File: rtl/seg_bank.sv
module seg_bank
  import seg_bank_pkg::*;
#(
  parameter int unsigned         NUM_CORES = 8,   // at most 8: core field is 3 bits
  parameter int unsigned         DATA_W    = 32,
  parameter logic [NUM_SEGS-1:0] IMPL_MASK = IMPL_DEFAULT
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CORES-1:0]             core_run_i,
  input  logic [NUM_CORES-1:0]             loc_set_i,
  input  logic [NUM_CORES-1:0]             loc_get_i,
  input  logic [NUM_CORES*SEL_W-1:0]       loc_idx_i,
  input  logic [NUM_CORES*DATA_W-1:0]      loc_wdata_i,
  output logic [NUM_CORES*DATA_W-1:0]      loc_rdata_o,
  output logic [NUM_CORES-1:0]             loc_rvalid_o,
  input  logic                             init_valid_i,
  input  logic [8:0]                       init_dst_i,
  input  logic [DATA_W-1:0]                init_src_i,
  output logic [NUM_CORES*HALF*DATA_W-1:0] seg_base_o,
  output logic [NUM_CORES*HALF*DATA_W-1:0] seg_lim_o
);
  localparam int unsigned SLICE_W = HALF * DATA_W;

  logic [NUM_CORES-1:0] init_we;
  logic [SEL_W-1:0]     init_sel;
  logic                 init_lock;

  seg_init_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_valid_i (init_valid_i),
    .init_dst_i   (init_dst_i),
    .core_run_i   (core_run_i),
    .init_we_o    (init_we),
    .init_sel_o   (init_sel),
    .init_lock_o  (init_lock)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    seg_core_regs #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .init_we_i    (init_we[c]),
      .init_sel_i   (init_sel),
      .init_lock_i  (init_lock),
      .init_data_i  (init_src_i),
      .loc_set_i    (loc_set_i[c]),
      .loc_get_i    (loc_get_i[c]),
      .loc_idx_i    (loc_idx_i[c*SEL_W +: SEL_W]),
      .loc_wdata_i  (loc_wdata_i[c*DATA_W +: DATA_W]),
      .loc_rdata_o  (loc_rdata_o[c*DATA_W +: DATA_W]),
      .loc_rvalid_o (loc_rvalid_o[c]),
      .base_o       (seg_base_o[c*SLICE_W +: SLICE_W]),
      .lim_o        (seg_lim_o[c*SLICE_W +: SLICE_W])
    );

    a_r5_running_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_valid_i && init_dst_i[5:3] == 3'(c) && core_run_i[c]) |-> !init_we[c]);

    a_r9_other_core_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!init_we[c] && !loc_set_i[c]) |=>
        ($stable(seg_base_o[c*SLICE_W +: SLICE_W]) && $stable(seg_lim_o[c*SLICE_W +: SLICE_W])));
  end
endmodule

// File: tb/seg_bank_tb_top.sv
module seg_bank_tb_top;
  localparam int NC = 8;
  localparam int DW = 32;
  localparam logic [7:0] MASK = 8'b0110_0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NC-1:0]      run, set, get;
  logic [NC*3-1:0]    idx;
  logic [NC*DW-1:0]   wdata, rdata;
  logic [NC-1:0]      rvalid;
  logic               ivalid;
  logic [8:0]         idst;
  logic [DW-1:0]      isrc;
  logic [NC*4*DW-1:0] base, lim;

  seg_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .core_run_i(run), .loc_set_i(set), .loc_get_i(get),
    .loc_idx_i(idx), .loc_wdata_i(wdata), .loc_rdata_o(rdata), .loc_rvalid_o(rvalid),
    .init_valid_i(ivalid), .init_dst_i(idst), .init_src_i(isrc),
    .seg_base_o(base), .seg_lim_o(lim)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] m_reg [NC][8];
  logic          m_lock [NC];
  logic          e_rv [NC];
  logic [DW-1:0] e_rd [NC];

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    run = '0; set = '0; get = '0; idx = '0; wdata = '0;
    ivalid = 1'b0; idst = '0; isrc = '0;
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      for (int r = 0; r < 8; r++) m_reg[c][r] = '0;
      m_lock[c] = 1'b0; e_rv[c] = 1'b0; e_rd[c] = '0;
    end
  endtask

  // R2 R7 R9 outputs per core, R3 get result
  task automatic check_all(string ctx);
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < 4; k++) begin
        chk({ctx, " R2/R7/R9 base"}, base[(c*4+k)*DW +: DW], m_reg[c][k]);
        chk({ctx, " R2/R7/R9 lim"},  lim[(c*4+k)*DW +: DW],  m_reg[c][k+4]);
      end
      chk({ctx, " R3 rvalid"}, {31'd0, rvalid[c]}, {31'd0, e_rv[c]});
      if (e_rv[c]) chk({ctx, " R3 rdata"}, rdata[c*DW +: DW], e_rd[c]);
    end
  endtask

  // apply current inputs for one edge, update model, check at next negedge
  task automatic tick(string ctx);
    logic acc [NC];
    logic [2:0] tc, ts;
    tc = idst[5:3]; ts = idst[2:0];
    for (int c = 0; c < NC; c++) begin
      logic [2:0] li;
      li = idx[c*3 +: 3];
      e_rv[c] = get[c];
      e_rd[c] = m_reg[c][li];
      acc[c] = ivalid && (tc == 3'(c)) && !run[c];   // R4 R5
    end
    for (int c = 0; c < NC; c++) begin
      logic [2:0] li;
      li = idx[c*3 +: 3];
      // R6 lock in force this cycle; R8 init wins on same register
      if (set[c] && !m_lock[c] && MASK[li] && !(acc[c] && ts == li))
        m_reg[c][li] = wdata[c*DW +: DW];
      if (acc[c]) begin
        if (MASK[ts]) m_reg[c][ts] = isrc;
        m_lock[c] = idst[8];
      end
    end
    @(negedge clk);
    check_all(ctx);
    idle();
  endtask

  task automatic lset(int c, int i, logic [DW-1:0] d);
    set[c] = 1'b1; idx[c*3 +: 3] = 3'(i); wdata[c*DW +: DW] = d;
  endtask

  task automatic lget(int c, int i);
    get[c] = 1'b1; idx[c*3 +: 3] = 3'(i);
  endtask

  task automatic icmd(bit lk, int c, int s, logic [DW-1:0] d);
    ivalid = 1'b1; idst = {lk, 2'b00, 3'(c), 3'(s)}; isrc = d;
  endtask

  task automatic run_all();
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // R2 base and limit write, R3 readback
    lset(2, 1, 32'hA5A5_0001); tick("R2 set data base");
    lset(2, 5, 32'h0000_FFF0); lget(3, 1); tick("R2 set data limit");
    lget(2, 1); tick("R3 get");
    lget(2, 5); lset(1, 0, 32'h1111_0000); tick("R3 get limit");
    // R3 same-cycle set and get returns old value
    lset(2, 1, 32'hDEAD_0002); get[2] = 1'b1; tick("R3 old value");
    // R7 reserved
    lset(2, 3, 32'hCCCC_CCCC); tick("R7 write ext base");
    lset(2, 7, 32'h7777_7777); tick("R7 write ext lim");
    lget(2, 3); icmd(1'b0, 2, 4, 32'h4444_4444); tick("R7 init code lim");
    lget(2, 4); tick("R7 read code lim");
    // R5 refused while running
    run[4] = 1'b1; icmd(1'b1, 4, 0, 32'hBAD0_BAD0); tick("R5 refused");
    lset(4, 0, 32'h0404_0000); tick("R5 lock unchanged");
    // R4 accepted, R6 locking
    icmd(1'b1, 4, 2, 32'h0D0D_0D0D); idst[7:6] = 2'b11; tick("R4 init accepted");
    lset(4, 2, 32'hEEEE_EEEE); tick("R6 locked set ignored");
    lset(4, 6, 32'hEEEE_0006); tick("R6 locked limit ignored");
    icmd(1'b0, 4, 6, 32'h0000_6000); lset(4, 0, 32'hEE00_0000); tick("R6 unlock same cycle");
    lset(4, 0, 32'h0400_0400); tick("R6 unlocked set");
    // R8 conflicts
    icmd(1'b0, 1, 0, 32'hF0F0_F0F0); lset(1, 0, 32'h0606_0606); tick("R8 same reg");
    icmd(1'b0, 1, 1, 32'h1234_5678); lset(1, 2, 32'h8765_4321); tick("R8 diff reg");
    lget(1, 0); lget(4, 2); tick("R8 readback");

    // random
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < NC; c++) begin
        run[c] = ($urandom % 4) == 0;
        set[c] = $urandom % 2;
        get[c] = $urandom % 2;
        idx[c*3 +: 3] = 3'($urandom);
        wdata[c*DW +: DW] = $urandom;
      end
      ivalid = ($urandom % 3) == 0;
      idst = 9'($urandom);
      isrc = $urandom;
      tick("rand R2 R4 R5 R6 R8");
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule